// File: doc/BRIEF.md
# Shared Counting Semaphore Bank

This block holds a bank of hardware counting semaphores that several instruction threads and a host write port share. Every entry keeps a 4-bit count and a 4-bit limit. Each source can issue one operation per cycle:

- an initialise, which loads both the count and the limit;
- a post, which adds one to the count;
- a get, which takes one from the count.

An operation acts on every entry that is set in its 8-bit select mask, so bit i of the mask addresses entry i.

The bank drives two flags for each entry at all times. The empty flag shows that the count is zero. The full flag shows that the count has reached the limit or gone past it. Wait gates in every thread watch these flags, so they can hold back work when nothing has been posted or when there is no room left. The bank takes all requests from all sources in the same cycle. Same-cycle collisions on one entry resolve inside the bank, so a change from any source shows on the shared flags one cycle later.

The default has four sources: indices 0 to 2 are the threads and index 3 is the host port. Counts saturate at the ends of their range. A sticky error output records every clamp.

Top module: `sem_bank`

## Requirements
- R1: After reset every count and every limit is 0, `sem_err` is 0, and every bit of `sem_empty` and `sem_full` is 1.
- R2: A source with `src_valid` set and operation code 2'b01 (initialise) loads its `src_init_cnt` into the count, and its `src_init_lim` into the limit, of every entry selected in its mask. Entries outside the mask keep their state.
- R3: Operation code 2'b10 (post) adds one to the count of each selected entry. Code 2'b11 (get) subtracts one from it. The limit does not change.
- R4: Posts and gets from different sources on the same entry in the same cycle are summed. The entry moves by the net amount.
- R5: If the net result would exceed 15, the count becomes 15. If it would fall below 0, the count becomes 0. Either case sets `sem_err`. Once set, `sem_err` stays at 1 until reset, and it is never set while no clamp happens.
- R6: An initialise on an entry overrides every post and get on that entry in the same cycle. When several sources initialise the same entry, the lowest source index wins.
- R7: `sem_empty[i]` is 1 exactly when count i is 0. `sem_full[i]` is 1 exactly when count i is greater than or equal to limit i. Both flags follow the stored state and change in the cycle after the operation that updates it.
- R8: A source with `src_valid` low, or with operation code 2'b00, has no effect on any count, any limit or `sem_err`.
- R9: Each source can issue a new operation every cycle, and every operation issued back to back is applied.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| src_valid | input | N_SRC | Request valid per source (index 3 is the host port) |
| src_op | input | 2*N_SRC | Operation code per source: 00 none, 01 initialise, 10 post, 11 get |
| src_mask | input | N_SRC*N_SEM | Entry select mask per source |
| src_init_cnt | input | N_SRC*4 | Count loaded by an initialise |
| src_init_lim | input | N_SRC*4 | Limit loaded by an initialise |
| sem_cnt | output | N_SEM*4 | Current count of every entry |
| sem_lim | output | N_SEM*4 | Current limit of every entry |
| sem_empty | output | N_SEM | Count equals zero, per entry |
| sem_full | output | N_SEM | Count at or above limit, per entry |
| sem_err | output | 1 | Sticky saturation error |

## Verification
Every result of an operation is due one clock edge after the edge that samples it. This covers the counts, limits, both flag vectors and the error bit, because the flags are decoded straight from the registered state with no further stage. The bench changes inputs on the falling edge and updates its own model of the bank at the same point. It compares every output at the next falling edge, which keeps the expected and the actual values aligned on the same edge. Back-to-back operations therefore get checked one per cycle, without gaps between them.

// File: rtl/sem_pkg.sv
package sem_pkg;

    localparam int SEM_VAL_W = 4;
    localparam int SEM_MAX   = (1 << SEM_VAL_W) - 1;
    // Net-delta width: holds +/- 127 simultaneous requests per entry.
    localparam int DELTA_W   = 8;

    typedef enum logic [1:0] {
        OP_NONE = 2'b00,
        OP_INIT = 2'b01,
        OP_POST = 2'b10,
        OP_GET  = 2'b11
    } sem_op_e;

    typedef struct packed {
        logic [SEM_VAL_W-1:0] cnt;
        logic [SEM_VAL_W-1:0] lim;
    } sem_state_t;

    // Returns {clamped, new_count} after adding a signed delta.
    function automatic logic [SEM_VAL_W:0] sat_apply(
        input logic [SEM_VAL_W-1:0]      cnt,
        input logic signed [DELTA_W-1:0] d
    );
        logic signed [DELTA_W+1:0] sum;
        sum = (DELTA_W+2)'($signed({1'b0, cnt})) + (DELTA_W+2)'(d);
        if (sum > SEM_MAX)
            return {1'b1, SEM_VAL_W'(SEM_MAX)};
        else if (sum < 0)
            return {1'b1, {SEM_VAL_W{1'b0}}};
        else
            return {1'b0, sum[SEM_VAL_W-1:0]};
    endfunction

endpackage

// File: rtl/sem_arbiter.sv
module sem_arbiter
    import sem_pkg::*;
#(
    parameter int N_SEM = 8,
    parameter int N_SRC = 4,
    localparam int VAL_W = SEM_VAL_W
)(
    input  logic [N_SRC-1:0]         src_valid,
    input  logic [2*N_SRC-1:0]       src_op,
    input  logic [N_SRC*N_SEM-1:0]   src_mask,
    input  logic [N_SRC*VAL_W-1:0]   src_init_cnt,
    input  logic [N_SRC*VAL_W-1:0]   src_init_lim,
    output logic [N_SEM-1:0]         init_hit_o,
    output sem_state_t               init_st_o [N_SEM],
    output logic signed [DELTA_W-1:0] delta_o [N_SEM]
);

    always_comb begin
        for (int e = 0; e < N_SEM; e++) begin
            init_hit_o[e] = 1'b0;
            init_st_o[e]  = '0;
            delta_o[e]    = '0;
            // Walk from the highest index down so the lowest index wins an init.
            for (int s = N_SRC - 1; s >= 0; s--) begin
                if (src_valid[s] && src_mask[s*N_SEM + e]) begin
                    case (sem_op_e'(src_op[2*s +: 2]))
                        OP_INIT: begin
                            init_hit_o[e]    = 1'b1;
                            init_st_o[e].cnt = src_init_cnt[s*VAL_W +: VAL_W];
                            init_st_o[e].lim = src_init_lim[s*VAL_W +: VAL_W];
                        end
                        OP_POST: delta_o[e] = delta_o[e] + DELTA_W'(1);
                        OP_GET:  delta_o[e] = delta_o[e] - DELTA_W'(1);
                        default: ;
                    endcase
                end
            end
        end
    end

endmodule

// File: rtl/sem_entry.sv
module sem_entry
    import sem_pkg::*;
(
    input  logic                      clk,
    input  logic                      rst,
    input  logic                      init_hit,
    input  sem_state_t                init_st,
    input  logic signed [DELTA_W-1:0] delta,
    output sem_state_t                st,
    output logic                      empty_o,
    output logic                      full_o,
    output logic                      clamp_o
);

    logic [SEM_VAL_W:0] sat;

    assign sat     = sat_apply(st.cnt, delta);
    assign clamp_o = !init_hit && sat[SEM_VAL_W];
    assign empty_o = (st.cnt == '0);
    assign full_o  = (st.cnt >= st.lim);

    always_ff @(posedge clk) begin
        if (rst)
            st <= '0;
        else if (init_hit)
            st <= init_st;
        else
            st.cnt <= sat[SEM_VAL_W-1:0];
    end

endmodule

// File: rtl/sem_bank.sv
module sem_bank
    import sem_pkg::*;
#(
    parameter int N_SEM = 8,
    parameter int N_SRC = 4,
    localparam int VAL_W = SEM_VAL_W
)(
    input  logic                     clk,
    input  logic                     rst,
    input  logic [N_SRC-1:0]         src_valid,
    input  logic [2*N_SRC-1:0]       src_op,
    input  logic [N_SRC*N_SEM-1:0]   src_mask,
    input  logic [N_SRC*VAL_W-1:0]   src_init_cnt,
    input  logic [N_SRC*VAL_W-1:0]   src_init_lim,
    output logic [N_SEM*VAL_W-1:0]   sem_cnt,
    output logic [N_SEM*VAL_W-1:0]   sem_lim,
    output logic [N_SEM-1:0]         sem_empty,
    output logic [N_SEM-1:0]         sem_full,
    output logic                     sem_err
);

    logic [N_SEM-1:0]          init_hit;
    sem_state_t                init_st [N_SEM];
    logic signed [DELTA_W-1:0] delta   [N_SEM];
    sem_state_t                st      [N_SEM];
    logic [N_SEM-1:0]          clamp;

    sem_arbiter #(.N_SEM(N_SEM), .N_SRC(N_SRC)) u_arb (
        .src_valid    (src_valid),
        .src_op       (src_op),
        .src_mask     (src_mask),
        .src_init_cnt (src_init_cnt),
        .src_init_lim (src_init_lim),
        .init_hit_o   (init_hit),
        .init_st_o    (init_st),
        .delta_o      (delta)
    );

    for (genvar e = 0; e < N_SEM; e++) begin : g_ent
        sem_entry u_ent (
            .clk      (clk),
            .rst      (rst),
            .init_hit (init_hit[e]),
            .init_st  (init_st[e]),
            .delta    (delta[e]),
            .st       (st[e]),
            .empty_o  (sem_empty[e]),
            .full_o   (sem_full[e]),
            .clamp_o  (clamp[e])
        );
        assign sem_cnt[e*VAL_W +: VAL_W] = st[e].cnt;
        assign sem_lim[e*VAL_W +: VAL_W] = st[e].lim;
    end

    always_ff @(posedge clk) begin
        if (rst)
            sem_err <= 1'b0;
        else if (|clamp)
            sem_err <= 1'b1;
    end

endmodule

// File: rtl/sem_bank_chk.sv
module sem_bank_chk #(
    parameter int N_SEM = 8,
    parameter int N_SRC = 4,
    parameter int VAL_W = 4
)(
    input logic                   clk,
    input logic                   rst,
    input logic [N_SRC-1:0]       src_valid,
    input logic [N_SEM*VAL_W-1:0] sem_cnt,
    input logic [N_SEM*VAL_W-1:0] sem_lim,
    input logic [N_SEM-1:0]       sem_empty,
    input logic [N_SEM-1:0]       sem_full,
    input logic                   sem_err
);

    AST_RESET_CLEARS: assert property (@(posedge clk)
        rst |=> (sem_cnt == '0 && sem_lim == '0 && !sem_err)); // R1

    AST_ERR_STICKY: assert property (@(posedge clk) disable iff (rst)
        sem_err |=> sem_err); // R5

    AST_IDLE_NO_ERR: assert property (@(posedge clk) disable iff (rst)
        (src_valid == '0 && !sem_err) |=> !sem_err); // R5

    AST_IDLE_HOLDS: assert property (@(posedge clk) disable iff (rst)
        (src_valid == '0) |=> ($stable(sem_cnt) && $stable(sem_lim))); // R8

    for (genvar e = 0; e < N_SEM; e++) begin : g_flag
        AST_EMPTY_FULL_LINK: assert property (@(posedge clk) disable iff (rst)
            sem_empty[e] |-> (sem_full[e] == (sem_lim[e*VAL_W +: VAL_W] == '0))); // R7
    end

endmodule

bind sem_bank sem_bank_chk #(.N_SEM(N_SEM), .N_SRC(N_SRC), .VAL_W(VAL_W)) u_chk (
    .clk       (clk),
    .rst       (rst),
    .src_valid (src_valid),
    .sem_cnt   (sem_cnt),
    .sem_lim   (sem_lim),
    .sem_empty (sem_empty),
    .sem_full  (sem_full),
    .sem_err   (sem_err)
);

// File: tb/test_sem_bank.sv
module test_sem_bank;

    localparam int CLK_PERIOD = 10;
    localparam int NS = 8;
    localparam int NR = 4;

    logic            clk = 1'b0;
    logic            rst = 1'b1;
    logic [NR-1:0]   src_valid;
    logic [2*NR-1:0] src_op;
    logic [NR*NS-1:0] src_mask;
    logic [NR*4-1:0] src_init_cnt;
    logic [NR*4-1:0] src_init_lim;
    logic [NS*4-1:0] sem_cnt;
    logic [NS*4-1:0] sem_lim;
    logic [NS-1:0]   sem_empty;
    logic [NS-1:0]   sem_full;
    logic            sem_err;

    int  n_checks = 0;
    int  n_fail   = 0;
    bit  done     = 0;
    int  m_cnt [NS];
    int  m_lim [NS];
    bit  m_err;

    always #(CLK_PERIOD/2) clk = ~clk;

    sem_bank i_sem_bank (
        .clk(clk), .rst(rst), .src_valid(src_valid), .src_op(src_op),
        .src_mask(src_mask), .src_init_cnt(src_init_cnt), .src_init_lim(src_init_lim),
        .sem_cnt(sem_cnt), .sem_lim(sem_lim), .sem_empty(sem_empty),
        .sem_full(sem_full), .sem_err(sem_err)
    );

    task automatic check(input bit ok, input string tag, input int act, input int exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d at %0t", tag, act, exp, $time);
        end
    endtask

    task automatic idle_inputs();
        src_valid = '0; src_op = '0; src_mask = '0;
        src_init_cnt = '0; src_init_lim = '0;
    endtask

    task automatic set_src(input int s, input logic [1:0] op, input logic [7:0] msk,
                           input logic [3:0] ic, input logic [3:0] il);
        src_valid[s] = 1'b1;
        src_op[2*s +: 2] = op;
        src_mask[s*NS +: NS] = msk;
        src_init_cnt[s*4 +: 4] = ic;
        src_init_lim[s*4 +: 4] = il;
    endtask

    task automatic model_reset();
        for (int e = 0; e < NS; e++) begin m_cnt[e] = 0; m_lim[e] = 0; end
        m_err = 0;
    endtask

    // Next-state model taken from the requirements (R2..R6, R8).
    task automatic model_step();
        for (int e = 0; e < NS; e++) begin
            int hit_src = -1;
            int net = 0;
            for (int s = 0; s < NR; s++) begin
                if (src_valid[s] && src_mask[s*NS + e]) begin
                    case (src_op[2*s +: 2])
                        2'b01: if (hit_src < 0) hit_src = s;
                        2'b10: net++;
                        2'b11: net--;
                        default: ;
                    endcase
                end
            end
            if (hit_src >= 0) begin
                m_cnt[e] = int'(src_init_cnt[hit_src*4 +: 4]);
                m_lim[e] = int'(src_init_lim[hit_src*4 +: 4]);
            end else begin
                int r = m_cnt[e] + net;
                if (r > 15) begin r = 15; m_err = 1; end
                if (r < 0)  begin r = 0;  m_err = 1; end
                m_cnt[e] = r;
            end
        end
    endtask

    task automatic compare_all(input string tag);
        for (int e = 0; e < NS; e++) begin
            check(int'(sem_cnt[e*4 +: 4]) == m_cnt[e], tag, int'(sem_cnt[e*4 +: 4]), m_cnt[e]);
            check(int'(sem_lim[e*4 +: 4]) == m_lim[e], tag, int'(sem_lim[e*4 +: 4]), m_lim[e]);
            check(sem_empty[e] == (m_cnt[e] == 0), "R7 empty", int'(sem_empty[e]), int'(m_cnt[e] == 0));
            check(sem_full[e] == (m_cnt[e] >= m_lim[e]), "R7 full", int'(sem_full[e]), int'(m_cnt[e] >= m_lim[e]));
        end
        check(sem_err == m_err, "R5 err", int'(sem_err), int'(m_err));
    endtask

    // Applies the driven inputs for one edge, then compares at the next falling edge.
    task automatic step(input string tag);
        model_step();
        @(posedge clk);
        @(negedge clk);
        compare_all(tag);
        idle_inputs();
    endtask

    task automatic do_reset();
        rst = 1'b1;
        idle_inputs();
        repeat (2) @(negedge clk);
        rst = 1'b0;
        model_reset();
        compare_all("R1");
    endtask

    initial begin
        void'($urandom(32'd2024));
        idle_inputs();
        do_reset();

        // R2: initialise two groups from two sources
        set_src(0, 2'b01, 8'h0F, 4'd3, 4'd5);
        set_src(1, 2'b01, 8'hF0, 4'd0, 4'd2);
        step("R2");

        // R3: single post and single get
        set_src(2, 2'b10, 8'h01, 4'd0, 4'd0);
        set_src(3, 2'b11, 8'h02, 4'd0, 4'd0);
        step("R3");

        // R9: back-to-back posts from one source, full flag crosses limit (R7)
        for (int k = 0; k < 3; k++) begin
            set_src(0, 2'b10, 8'h01, 4'd0, 4'd0);
            step("R9");
        end

        // R4: three posts and one get on entry 4 in one cycle
        set_src(0, 2'b10, 8'h10, 4'd0, 4'd0);
        set_src(1, 2'b10, 8'h10, 4'd0, 4'd0);
        set_src(2, 2'b10, 8'h10, 4'd0, 4'd0);
        set_src(3, 2'b11, 8'h10, 4'd0, 4'd0);
        step("R4");
        check(int'(sem_cnt[16 +: 4]) == 2, "R4 net", int'(sem_cnt[16 +: 4]), 2);

        // R8: op code none with valid, and valid low with a post code
        set_src(0, 2'b00, 8'hFF, 4'd7, 4'd7);
        src_op[2*1 +: 2] = 2'b10; src_mask[1*NS +: NS] = 8'hFF;
        step("R8");

        // R6: two inits and a post on entry 5; source 1 must win
        set_src(1, 2'b01, 8'h20, 4'd9, 4'd9);
        set_src(2, 2'b01, 8'h20, 4'd1, 4'd3);
        set_src(0, 2'b10, 8'h20, 4'd0, 4'd0);
        step("R6");
        check(int'(sem_cnt[20 +: 4]) == 9, "R6 winner", int'(sem_cnt[20 +: 4]), 9);

        // R5: overflow at 15, then underflow at 0
        set_src(3, 2'b01, 8'h40, 4'd15, 4'd15);
        step("R5");
        check(sem_err == 1'b0, "R5 no clamp yet", int'(sem_err), 0);
        set_src(3, 2'b10, 8'h40, 4'd0, 4'd0);
        step("R5");
        check(int'(sem_cnt[24 +: 4]) == 15 && sem_err, "R5 saturate", int'(sem_cnt[24 +: 4]), 15);
        set_src(2, 2'b11, 8'h80, 4'd0, 4'd0);
        step("R5");
        check(int'(sem_cnt[28 +: 4]) == 0, "R5 floor", int'(sem_cnt[28 +: 4]), 0);
        step("R5");
        check(sem_err == 1'b1, "R5 sticky", int'(sem_err), 1);

        // Random mix from all sources, model tracks everything (R3, R4, R6, R9)
        do_reset();
        for (int c = 0; c < 3000; c++) begin
            for (int s = 0; s < NR; s++) begin
                if (($urandom % 10) < 7) begin
                    int r = $urandom % 10;
                    logic [1:0] op;
                    if (r == 0) op = 2'b01;
                    else if (r == 1) op = 2'b00;
                    else if (r < 6) op = 2'b10;
                    else op = 2'b11;
                    set_src(s, op, 8'($urandom), 4'($urandom), 4'($urandom));
                end
            end
            step("R4 random");
        end

        done = 1;
        $display("TB_RESULT checks=%0d failures=%0d", n_checks, n_fail);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_checks++;
            n_fail++;
            $display("FAIL watchdog expired actual=0 expected=1");
            $display("TB_RESULT checks=%0d failures=%0d", n_checks, n_fail);
            $finish;
        end
    end

endmodule